// File: doc/BRIEF.md
# Wrapped Wavefront Crossbar Switch Allocator

This block decides, in a single cycle, which router input may drive which crossbar output. Each of the N inputs (N = 5 by default) presents one request bit for each output, and the block returns a grant matrix of the same shape. No output and no input receives more than one grant in a cycle.

The request matrix is split into N wrapped diagonals. Diagonal d holds the cells (i, (i+d) mod N), one per input. No two cells on a diagonal share an input or an output, so every request on one diagonal can be granted together. A registered pointer names the diagonal that has top priority. The other diagonals are then visited in rising order from there, modulo N. A cell on one of them is granted only if its input row and its output column are both still unclaimed. The pointer moves on by one in every cycle that issues at least one grant, so top priority sweeps across all diagonals.

The cell for input i and output j sits at bit i*N + j of both the request and the grant vector. Grants are combinational from the current requests and the registered pointer.

Top module: `wwf_switch_alloc`

## Requirements
- R1: A grant bit is set only where the matching request bit is set in the same cycle.
- R2: For every output j, at most one of the grant bits i*N + j is set.
- R3: For every input i, at most one of the grant bits i*N + j is set.
- R4: Every requested cell on the top-priority diagonal p, meaning the cells (i, (i+p) mod N) at bit i*N + (i+p) mod N, is granted.
- R5: Diagonals are visited in the order p, p+1, ... modulo N. A requested cell is granted exactly when its row and column are both still free at its turn. As a result, a requested cell left without a grant always has its row or its column granted elsewhere.
- R6: The priority pointer advances by one modulo N after each cycle that has at least one grant. It keeps its value after a cycle with no grant.
- R7: Reset, active low and synchronous, sets the priority pointer to diagonal 0 and holds it there while reset is asserted.
- R8: With all N*N requests set, exactly N grants are given, and they form a permutation of inputs to outputs.
- R9: A request set continuously, with every other request also set, is granted within N consecutive cycles.
- R10: The grant for a request appears in the same cycle as the request, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N*N | Request matrix; bit i*N+j means input i asks for output j |
| gnt_o | output | N*N | Grant matrix in the same encoding |

## Verification
A full request matrix shows whether the granted diagonal follows the rotating pointer, and whether every cell is served within N cycles. Two inputs competing for one output show which diagonal visit order is used. One input asking for two outputs shows how row blocking works. A matrix with only the priority diagonal missing shows that the next diagonal takes over. A mixed case, where an early grant blocks both a row and a column, shows that later diagonals fill only the free positions. An all-zero matrix shows that the pointer holds. Pseudo-random matrices, compared against an output-major model, cover the rest.

// File: rtl/wwf_pkg.sv
package wwf_pkg;

    // Wrapped sum used for diagonal and column indexing.
    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/wwf_diag_view.sv
module wwf_diag_view #(
    parameter int N = 5
) (
    input  logic [N*N-1:0] req_i,
    output logic [N*N-1:0] dreq_o   // bit d*N+i : cell (i,(i+d)%N) requested
);
    for (genvar d = 0; d < N; d++) begin : g_diag
        for (genvar i = 0; i < N; i++) begin : g_row
            localparam int COL = (i + d) % N;
            assign dreq_o[d*N + i] = req_i[i*N + COL];
        end
    end
endmodule

// File: rtl/wwf_prio_ptr.sv
module wwf_prio_ptr #(
    parameter int N  = 5,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    output logic [PW-1:0] ptr_o
);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            state_d.ptr = (state_q.ptr == LAST) ? '0 : state_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ptr_o = state_q.ptr;

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ptr <= LAST);
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (state_q.ptr == (($past(state_q.ptr) == LAST) ? '0 : $past(state_q.ptr) + 1'b1)));
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q.ptr));
endmodule

// File: rtl/wwf_alloc_core.sv
module wwf_alloc_core
    import wwf_pkg::*;
#(
    parameter int N  = 5,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N*N-1:0] dreq_i,  // diagonal-major requests
    input  logic [PW-1:0]  ptr_i,
    output logic [N*N-1:0] gnt_o    // row-major grants
);
    logic [N-1:0]   row_free, col_free;
    logic [N*N-1:0] gnt_d;

    always_comb begin
        row_free = '1;
        col_free = '1;
        gnt_d    = '0;
        for (int k = 0; k < N; k++) begin
            for (int i = 0; i < N; i++) begin
                if (dreq_i[wrap_add(int'(ptr_i), k, N)*N + i]
                    && row_free[i]
                    && col_free[wrap_add(i, wrap_add(int'(ptr_i), k, N), N)]) begin
                    gnt_d[i*N + wrap_add(i, wrap_add(int'(ptr_i), k, N), N)] = 1'b1;
                    row_free[i] = 1'b0;
                    col_free[wrap_add(i, wrap_add(int'(ptr_i), k, N), N)] = 1'b0;
                end
            end
        end
    end

    assign gnt_o = gnt_d;

    // R4: every request on the top diagonal is served.
    for (genvar i = 0; i < N; i++) begin : g_prio_chk
        p_prio_diag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            dreq_i[int'(ptr_i)*N + i] |-> gnt_o[i*N + wrap_add(i, int'(ptr_i), N)]);
    end

    // R8: a full request matrix yields exactly N grants.
    p_full_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&dreq_i) |-> ($countones(gnt_o) == N));
endmodule

// File: rtl/wwf_switch_alloc.sv
module wwf_switch_alloc #(
    parameter int N = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*N-1:0] req_i,
    output logic [N*N-1:0] gnt_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [N*N-1:0] dreq;
    logic [PW-1:0]  ptr;
    logic           any_gnt;

    wwf_diag_view #(.N(N)) u_view (
        .req_i  (req_i),
        .dreq_o (dreq)
    );

    wwf_alloc_core #(.N(N), .PW(PW)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .dreq_i (dreq),
        .ptr_i  (ptr),
        .gnt_o  (gnt_o)
    );

    assign any_gnt = |gnt_o;

    wwf_prio_ptr #(.N(N), .PW(PW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (any_gnt),
        .ptr_o (ptr)
    );

    // Row and column occupancy seen from the grant port.
    logic [N-1:0] row_any, col_any;
    for (genvar i = 0; i < N; i++) begin : g_occ
        logic [N-1:0] row_bits, col_bits;
        for (genvar j = 0; j < N; j++) begin : g_bit
            assign row_bits[j] = gnt_o[i*N + j];
            assign col_bits[j] = gnt_o[j*N + i];
        end
        assign row_any[i] = |row_bits;
        assign col_any[i] = |col_bits;

        p_col_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_bits));
        p_row_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(row_bits));
    end

    p_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);

    // R5: a refused request is blocked by its row or its column.
    for (genvar c = 0; c < N*N; c++) begin : g_max
        p_maximal_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[c] && !gnt_o[c]) |-> (row_any[c / N] || col_any[c % N]));
    end
endmodule

// File: tb/sim_wwf_switch_alloc.sv
module sim_wwf_switch_alloc;
    localparam int N  = 5;
    localparam int NN = N * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NN-1:0] req = '0;
    logic [NN-1:0] gnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int bm_ptr = 0;

    always #10 clk = ~clk;   // 50 MHz

    wwf_switch_alloc #(.N(N)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .gnt_o (gnt)
    );

    typedef struct packed {
        logic [NN-1:0] req;
        logic [NN-1:0] gnt;
    } vec_t;

    // Walked from pointer 0 right after reset; one entry per cycle.
    localparam vec_t TAB [10] = '{
        '{25'h1FFFFFF, 25'h1041041},  // full, diag 0            R8
        '{25'h1FFFFFF, 25'h0182082},  // full, diag 1            R6
        '{25'h0000000, 25'h0000000},  // idle, pointer holds     R6
        '{25'h0010000, 25'h0010000},  // lone cell (3,1)         R10
        '{25'h0004010, 25'h0000010},  // out 4 contested, ptr 3  R5
        '{25'h0004010, 25'h0000010},  // ptr 4                   R5
        '{25'h0004010, 25'h0004000},  // ptr 0, other input wins R5
        '{25'h0000120, 25'h0000100},  // input 1 wants two outs  R3
        '{25'h1DF3EFB, 25'h0410608},  // top diag empty, next    R4
        '{25'h0000069, 25'h0000028}   // row/col blocking        R5
    };

    task automatic check(input bit ok, input string tag,
                         input logic [NN-1:0] act, input logic [NN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: visit diagonals from the pointer, scan by output column.
    function automatic logic [NN-1:0] ref_alloc(input logic [NN-1:0] r, input int p);
        logic [NN-1:0] g = '0;
        bit rb [N];
        bit cb [N];
        for (int x = 0; x < N; x++) begin rb[x] = 0; cb[x] = 0; end
        for (int k = 0; k < N; k++) begin
            int d = (p + k) % N;
            for (int j = 0; j < N; j++) begin
                int i = (j - d + N) % N;
                if (r[i*N + j] && !rb[i] && !cb[j]) begin
                    g[i*N + j] = 1'b1; rb[i] = 1; cb[j] = 1;
                end
            end
        end
        return g;
    endfunction

    function automatic bit is_matching(input logic [NN-1:0] g);
        for (int a = 0; a < N; a++) begin
            int rc = 0, cc = 0;
            for (int b = 0; b < N; b++) begin
                rc += int'(g[a*N + b]);
                cc += int'(g[b*N + a]);
            end
            if (rc > 1 || cc > 1) return 0;
        end
        return 1;
    endfunction

    function automatic bit is_perm(input logic [NN-1:0] g);
        return is_matching(g) && ($countones(g) == N);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic step_ptr(input logic [NN-1:0] g);
        if (g != '0) bm_ptr = (bm_ptr + 1) % N;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [NN-1:0] seen;
        logic [NN-1:0] lfsr;
        // Reset state: pointer at diagonal 0, held through reset (R7)
        req = '1;
        repeat (3) @(negedge clk);
        #5 check(gnt == 25'h1041041, "R7 reset diag0", gnt, 25'h1041041);
        @(negedge clk);
        #5 check(gnt == 25'h1041041, "R7 held in reset", gnt, 25'h1041041);
        @(negedge clk);
        rst_n = 1'b1;
        bm_ptr = 0;

        // Vector table (R4 R5 R6 R8 R10)
        for (int k = 0; k < 10; k++) begin
            req = TAB[k].req;
            #5 check(gnt == TAB[k].gnt, $sformatf("R5 R6 table %0d", k), gnt, TAB[k].gnt);
            step_ptr(TAB[k].gnt);
            @(negedge clk);
        end

        // Full request matrix: rotating permutation and service within N (R8 R9)
        req = '1;
        seen = '0;
        for (int c = 0; c < N; c++) begin
            logic [NN-1:0] e;
            e = '0;
            for (int i = 0; i < N; i++) e[i*N + (i + bm_ptr) % N] = 1'b1;
            #5 check(gnt == e, "R4 R6 full-matrix diagonal", gnt, e);
            check(is_perm(gnt), "R8 permutation", gnt, e);
            seen |= gnt;
            step_ptr(e);
            @(negedge clk);
        end
        check(seen == '1, "R9 all cells served within N", seen, '1);

        // Pseudo-random matrices against the reference (R1 R2 R3 R5 R6)
        lfsr = 25'h1A5F3C1;
        for (int c = 0; c < 300; c++) begin
            logic [NN-1:0] e;
            lfsr = {lfsr[23:0], lfsr[24] ^ lfsr[21]};
            req = (c % 7 == 0) ? (lfsr & (lfsr >> 3)) : lfsr;
            e = ref_alloc(req, bm_ptr);
            #5 check(gnt == e, "R5 random vs reference", gnt, e);
            check((gnt & ~req) == '0, "R1 subset", gnt, req);
            check(is_matching(gnt), "R2 R3 single grant per row/column", gnt, e);
            step_ptr(e);
            @(negedge clk);
        end

        finish_run();
    end
endmodule